// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects level or pulse interrupt requests from a parameterized number of sources and tells a small processor core which one to service next. Each source has an enable bit, a pending bit and a five-bit urgency value. The controller picks the most urgent source that is both pending and enabled. It raises a request toward the core only when that source outranks the handler that is already running.

The core reports two events. The first is entry into a handler (acknowledge), which clears the pending bit of the presented source and pushes its urgency onto a small stack of active levels. The second is end-of-service, which pops that stack so the level of any preempted handler is restored. Software reaches all state through a simple memory-mapped bus. The bus has word reads, per-byte write strobes, write-one-to-set and write-one-to-clear banks, and one byte-wide urgency register per source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enable bits, pending bits and urgency values are zero, and req_o is low.
- R2: Source n is bank n/32, bit n%32. The enable-set bank b is at byte offset 0x000+4b, and writing 1 to a bit enables the source. The enable-clear bank is at 0x040+4b, and writing 1 disables the source. Writing 0 to either bank changes nothing. Both offsets read the enable bits. Bits that belong to no implemented source read 0.
- R3: The pending-set bank is at 0x080+4b and the pending-clear bank is at 0x0C0+4b. They use the same bit mapping and the same write-1 rules as R2, and both offsets read the pending bits.
- R4: A pending source whose enable bit is 0 never drives req_o.
- R5: The urgency of source n is the byte at offset 0x100+n, so it is lane n%4 of word 0x100+4*(n/4). Only bits 7:3 are stored and bits 2:0 read 0. Bytes whose write strobe is low are left unchanged.
- R6: Among pending enabled sources the lowest urgency value wins and is shown on req_id_o. On a tie the lowest source number wins.
- R7: While req_o is high, ack_i clears the pending bit of the source on req_id_o at the clock edge. ack_i while req_o is low has no effect.
- R8: A source line held high is pending again right after its acknowledge. A line high for one clock pends exactly once.
- R9: With a handler active, req_o rises only for a winner whose value is strictly lower than the active level. An equal value waits.
- R10: eos_i restores the previously active level, or the idle state. Nesting is limited to STACK_DEPTH levels, and when the stack is full req_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Source request lines |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset, word aligned (misaligned accesses ignored) |
| bus_be_i | input | 4 | Byte write strobes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| req_o | output | 1 | Interrupt request to core |
| req_id_o | output | $clog2(NUM_IRQ) | Number of the presented source |
| ack_i | input | 1 | Core enters presented handler |
| eos_i | input | 1 | Core finishes current handler |

## Verification
The bench builds the controller with NUM_IRQ = 40 and STACK_DEPTH = 2. The second bank is therefore only partly populated, which makes the read-as-zero bits of R2 visible. A two-level stack is filled after just two nested entries, so the full-stack blocking of R10 and the level restore after each end-of-service can be reached in a short run. The tie break, strict preemption and one-shot versus level re-pending are all driven on a few chosen sources.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  localparam int PRIO_W = 5;   // stored bits 7:3 of each urgency byte
  localparam int ADDR_W = 9;

  typedef enum logic [2:0] {
    RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR, RG_PRIO, RG_NONE
  } region_e;

  function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return RG_NONE;
    if (a[8]) return RG_PRIO;
    if (a[5]) return RG_NONE;
    case (a[7:6])
      2'd0:    return RG_EN_SET;
      2'd1:    return RG_EN_CLR;
      2'd2:    return RG_PD_SET;
      default: return RG_PD_CLR;
    endcase
  endfunction
endpackage

// File: rtl/prio_irq_regs.sv
`timescale 1ns/1ps
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_IRQ-1:0]             irq_i,
  input  logic                           bus_en_i,
  input  logic                           bus_we_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [3:0]                     bus_be_i,
  input  logic [31:0]                    bus_wdata_i,
  output logic [31:0]                    bus_rdata_o,
  input  logic [NUM_IRQ-1:0]             ack_clr_i,
  output logic [NUM_IRQ-1:0]             en_o,
  output logic [NUM_IRQ-1:0]             pend_o,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_o
);
  region_e    rg;
  logic [2:0] bank;
  logic [5:0] pword;
  logic       wr;

  assign rg    = bus_en_i ? decode_region(bus_addr_i) : RG_NONE;
  assign bank  = bus_addr_i[4:2];
  assign pword = bus_addr_i[7:2];
  assign wr    = bus_we_i && (rg != RG_NONE);

  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, prio_we;
  logic [NUM_IRQ-1:0] en_q, pend_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    localparam int BANK = i / 32;
    localparam int BIT  = i % 32;
    localparam int LANE = BIT / 8;
    logic hit;
    assign hit        = wr && (bank == 3'(BANK)) && bus_be_i[LANE] && bus_wdata_i[BIT];
    assign en_set[i]  = hit && (rg == RG_EN_SET);
    assign en_clr[i]  = hit && (rg == RG_EN_CLR);
    assign pd_set[i]  = hit && (rg == RG_PD_SET);
    assign pd_clr[i]  = hit && (rg == RG_PD_CLR);
    assign prio_we[i] = wr && (rg == RG_PRIO) && (pword == 6'(i / 4)) && bus_be_i[i % 4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      prio_q <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      // asserted lines win over any clear
      pend_q <= (pend_q & ~pd_clr & ~ack_clr_i) | pd_set | irq_i;
      for (int i = 0; i < NUM_IRQ; i++)
        if (prio_we[i]) prio_q[i] <= bus_wdata_i[(i % 4) * 8 + 3 +: PRIO_W];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      case (rg)
        RG_EN_SET, RG_EN_CLR: if (bank == 3'(i / 32)) bus_rdata_o[i % 32] = en_q[i];
        RG_PD_SET, RG_PD_CLR: if (bank == 3'(i / 32)) bus_rdata_o[i % 32] = pend_q[i];
        RG_PRIO: if (pword == 6'(i / 4)) bus_rdata_o[(i % 4) * 8 + 3 +: PRIO_W] = prio_q[i];
        default: ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign prio_o = prio_q;

  a_r8_line_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i)));
endmodule

// File: rtl/prio_irq_arb.sv
`timescale 1ns/1ps
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]             cand_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  output logic                           valid_o,
  output logic [ID_W-1:0]                id_o,
  output logic [PRIO_W-1:0]              prio_o
);
  // descending scan with <= leaves the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '1;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand_i[i] && (!valid_o || prio_i[i] <= prio_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
`timescale 1ns/1ps
module prio_irq_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH   = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [PRIO_W-1:0] top_o
);
  logic [DEPTH-1:0][PRIO_W-1:0] stk_q;
  logic [CNT_W-1:0] cnt_q, wr_pos, top_pos;
  logic pop_v, push_v;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign pop_v   = pop_i && !empty_o;
  assign push_v  = push_i && (!full_o || pop_v);
  assign wr_pos  = cnt_q - CNT_W'(pop_v);
  assign top_pos = cnt_q - CNT_W'(1);
  assign top_o   = empty_o ? '1 : stk_q[IDX_W'(top_pos)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stk_q <= '0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(pop_v) + CNT_W'(push_v);
      if (push_v) stk_q[IDX_W'(wr_pos)] <= push_prio_i;
    end
  end

  a_r10_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r10_pop_unwinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ     = 64,
  parameter int STACK_DEPTH = 4,
  localparam int ID_W       = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [3:0]         bus_be_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               req_o,
  output logic [ID_W-1:0]    req_id_o,
  input  logic               ack_i,
  input  logic               eos_i
);
  logic [NUM_IRQ-1:0]             en, pend, ack_clr;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic                           arb_valid, stk_empty, stk_full, take;
  logic [PRIO_W-1:0]              arb_prio, stk_top;

  prio_irq_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i, .rst_ni, .irq_i,
    .bus_en_i, .bus_we_i, .bus_addr_i, .bus_be_i, .bus_wdata_i, .bus_rdata_o,
    .ack_clr_i(ack_clr), .en_o(en), .pend_o(pend), .prio_o(prio)
  );

  prio_irq_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .cand_i(en & pend), .prio_i(prio),
    .valid_o(arb_valid), .id_o(req_id_o), .prio_o(arb_prio)
  );

  prio_irq_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .push_i(take), .push_prio_i(arb_prio), .pop_i(eos_i),
    .empty_o(stk_empty), .full_o(stk_full), .top_o(stk_top)
  );

  assign req_o   = arb_valid && !stk_full && (stk_empty || (arb_prio < stk_top));
  assign take    = ack_i && req_o;
  assign ack_clr = take ? ({{(NUM_IRQ-1){1'b0}}, 1'b1} << req_id_o) : '0;

  a_r4_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (en[req_id_o] && pend[req_id_o]));
  a_r9_strict_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !stk_empty) |-> (prio[req_id_o] < stk_top));
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !irq_i[req_id_o] && !bus_en_i) |=> !pend[$past(req_id_o)]);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int N  = 40;
  localparam int SD = 2;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic bus_en = 0, bus_we = 0, ack = 0, eos = 0;
  logic [8:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic req;
  logic [IW-1:0] req_id;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .STACK_DEPTH(SD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_be_i(bus_be),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .req_o(req), .req_id_o(req_id), .ack_i(ack), .eos_i(eos)
  );

  typedef struct { string tag; logic [31:0] exp; logic [31:0] act; } item_t;
  item_t sb_q[$];
  event sb_ev;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic drain();
    while (sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      n_run++;
      if (it.act !== it.exp) begin
        n_fail++;
        $display("FAIL %s act=%h exp=%h", it.tag, it.act, it.exp);
      end
    end
  endtask

  initial forever begin
    @(sb_ev);
    drain();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.act = act; it.exp = exp;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    tick();
    bus_en = 0; bus_we = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic pulse_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic pulse_eos(); eos = 1; tick(); eos = 0; endtask

  task automatic chk_req(input string tag, input logic r, input int id);
    chk({tag, " req"}, 32'(req), 32'(r));
    if (r) chk({tag, " id"}, 32'(req_id), 32'(id));
  endtask

  task automatic finish_run();
    drain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL all-reqs watchdog act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    #35 rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(9'h000, d); chk("R1 enable bank0", d, 0);
    rd(9'h080, d); chk("R1 pending bank0", d, 0);
    rd(9'h100, d); chk("R1 urgency word0", d, 0);
    chk_req("R1", 0, 0);

    // R2 enable banks, partial bank1 (sources 32..39)
    wr(9'h004, 32'hFFFF_FFFF, 4'hF);
    rd(9'h004, d); chk("R2 set bank1 unimpl bits zero", d, 32'h0000_00FF);
    wr(9'h044, 32'h0000_0001, 4'hF);
    rd(9'h044, d); chk("R2 clear bit via clear bank", d, 32'h0000_00FE);
    wr(9'h044, 32'h0, 4'hF);
    rd(9'h004, d); chk("R2 write 0 no effect", d, 32'h0000_00FE);
    wr(9'h044, 32'hFF, 4'hF);

    // R5 urgency bytes
    wr(9'h100, 32'hFFFF_FFFF, 4'b0101);
    rd(9'h100, d); chk("R5 strobes and low bits", d, 32'h00F8_00F8);
    wr(9'h100, 32'h0, 4'hF);

    // R3 / R4 pending without enable
    wr(9'h080, 32'h20, 4'hF);
    rd(9'h0C0, d); chk("R3 pending set", d, 32'h20);
    chk_req("R4 disabled pending", 0, 0);
    wr(9'h0C0, 32'h20, 4'hF);
    rd(9'h080, d); chk("R3 pending clear", d, 0);

    // R6 priority and tie break: 3->8, 7->4, 9->4
    wr(9'h100, 32'h4000_0000, 4'b1000);
    wr(9'h104, 32'h2000_0000, 4'b1000);
    wr(9'h108, 32'h0000_2000, 4'b0010);
    wr(9'h000, 32'h288, 4'hF);
    wr(9'h080, 32'h288, 4'hF);
    chk_req("R6 tie lowest id", 1, 7);

    // R7 ack clears, R9 equal level waits
    pulse_ack();
    rd(9'h080, d); chk("R7 ack clears pending", d, 32'h208);
    chk_req("R9 equal does not preempt", 0, 0);
    pulse_ack();
    rd(9'h080, d); chk("R7 ack ignored without req", d, 32'h208);

    // R9 preemption by 12 (value 1)
    wr(9'h10C, 32'h08, 4'b0001);
    wr(9'h000, 32'h1000, 4'hF);
    wr(9'h080, 32'h1000, 4'hF);
    chk_req("R9 strict preempt", 1, 12);
    pulse_ack();
    // R10 full stack blocks 13 (value 0)
    wr(9'h000, 32'h2000, 4'hF);
    wr(9'h080, 32'h2000, 4'hF);
    chk_req("R10 full stack blocks", 0, 0);
    pulse_eos();
    chk_req("R10 pop restores level 4", 1, 13);
    pulse_ack();
    pulse_eos();
    chk_req("R10 restored level blocks equal", 0, 0);
    pulse_eos();
    chk_req("R10 idle after last eos", 1, 9);
    pulse_ack();
    chk_req("R9 lower urgency waits", 0, 0);
    pulse_eos();
    chk_req("R6 remaining source", 1, 3);
    pulse_ack();
    pulse_eos();
    chk_req("R10 all serviced", 0, 0);

    // R8 one-clock pulse on 20 (value 2)
    wr(9'h114, 32'h10, 4'b0001);
    wr(9'h000, 32'h10_0000, 4'hF);
    irq[20] = 1; tick(); irq[20] = 0;
    rd(9'h080, d); chk("R8 pulse pends", d, 32'h10_0000);
    chk_req("R8 pulse request", 1, 20);
    pulse_ack();
    pulse_eos();
    rd(9'h080, d); chk("R8 pulse pends once", d, 0);
    chk_req("R8 no second request", 0, 0);

    // R8 level line re-pends
    irq[20] = 1; tick();
    chk_req("R8 level request", 1, 20);
    pulse_ack();
    rd(9'h080, d); chk("R8 level re-pends", d, 32'h10_0000);
    irq[20] = 0;
    pulse_eos();
    chk_req("R8 level serviced again", 1, 20);
    pulse_ack();
    pulse_eos();
    chk_req("R8 level released", 0, 0);

    done = 1;
    finish_run();
  end
endmodule